// File: doc/BRIEF.md
# Conditional Branch Target Unit

This block decides whether a sequencer branch instruction is taken and forms the next program counter. The program counter is 14 bits wide. A branch instruction supplies a 9-bit condition selector, an 11-bit page offset and a 2-bit bank number. The unit tests the selected condition against the flag sets of two accumulators (called A and B), the low nibble of the data pointer and a host request bit. One selector sends the sequencer to the address held in the serial-output register.

A taken branch keeps the top bit of the current program counter, places the bank number in bits 12:11 and the offset in bits 10:0. When the condition is false, or the selector is not assigned, the counter advances by one and wraps within 14 bits. The counter register changes only on a clock edge where the instruction-valid strobe is high.

Each flag set has six bits: carry, zero, overflow-0, overflow-1, sign-0 and sign-1.

Top module: `cbt_unit`

## Requirements
- R1: After reset, `pc_q` is 0. While `insn_vld` is low, `pc_q` holds its value.
- R2: A taken branch loads `pc_q` with {old `pc_q`[13], `bank`, `page_off`}.
- R3: Selector 0x000 always loads `pc_q` with `srl_out`[13:0].
- R4: Selectors 0x080 to 0x0AE test flag bits. The flag index is (sel-0x080)>>3, in the order carry, zero, ov0, ov1, sign0, sign1. sel[2] picks the B set (1) or the A set (0). sel[1] gives the level that branches: 1 branches when the flag is set, 0 branches when it is clear. sel[0] must be 0.
- R5: Selector 0x0B0 branches when `dp_lo` is 0, and 0x0B1 when it is not 0. Selector 0x0B2 branches when `dp_lo` is 0xF, and 0x0B3 when it is not 0xF.
- R6: Selectors 0x0B4, 0x0B6, 0x0B8 and 0x0BA never branch.
- R7: Selector 0x0BC branches when `rqm` is 0. Selector 0x0BE branches when `rqm` is 1.
- R8: A branch that is not taken, or a selector that is not assigned, loads `pc_q` with `pc_q`+1 modulo 2^14.
- R9: Bits of a flag vector are packed as [0]=ov0, [1]=ov1, [2]=zero, [3]=carry, [4]=sign0, [5]=sign1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| insn_vld | input | 1 | the instruction on the other inputs is valid this cycle |
| cond_sel | input | 9 | branch condition selector |
| page_off | input | 11 | target offset |
| bank | input | 2 | target bank |
| flg_a | input | 6 | accumulator A flags (packing as in R9) |
| flg_b | input | 6 | accumulator B flags (packing as in R9) |
| dp_lo | input | 4 | data-pointer low nibble |
| rqm | input | 1 | host request bit |
| srl_out | input | 16 | serial-output register |
| pc_q | output | 14 | program counter |

## Verification
The bench drives all 24 flag selectors with only the tested bit asserted and then with only that bit cleared. A design that decodes the wrong flag, the wrong set or the wrong polarity would branch in the wrong one of these cases. It starts from a counter with bit 13 set and checks that a taken branch keeps that bit. A design that cleared the bit would land in the low half of memory. It also steps from 0x3FFF to check the wrap to 0, and tries the serial-acknowledge selectors and an unassigned selector. A design that treated any of these as a branch would jump instead of falling through.

// File: rtl/cbt_unit.sv
module cbt_unit #(
  parameter int PC_W  = 14,
  parameter int OFF_W = 11,
  parameter int BNK_W = 2,
  parameter int SEL_W = 9,
  parameter int FLG_W = 6,
  parameter int SO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_vld,
  input  logic [SEL_W-1:0] cond_sel,
  input  logic [OFF_W-1:0] page_off,
  input  logic [BNK_W-1:0] bank,
  input  logic [FLG_W-1:0] flg_a,
  input  logic [FLG_W-1:0] flg_b,
  input  logic [3:0]       dp_lo,
  input  logic             rqm,
  input  logic [SO_W-1:0]  srl_out,
  output logic [PC_W-1:0]  pc_q
);
  localparam int FIX_W = PC_W - OFF_W - BNK_W;

  logic [PC_W-1:0]  tgt, seq_pc, pc_d;
  logic [FLG_W-1:0] fsel;
  logic             fbit, take, is_so;
  logic [2:0]       fidx;

  assign tgt    = {pc_q[PC_W-1 -: FIX_W], bank, page_off};
  assign seq_pc = pc_q + 1'b1;
  assign fsel   = cond_sel[2] ? flg_b : flg_a;
  assign fidx   = cond_sel[5:3];
  assign is_so  = (cond_sel == '0);

  // map selector flag index (c,z,ov0,ov1,s0,s1) to packed bit
  always_comb begin
    case (fidx)
      3'd0:    fbit = fsel[3];
      3'd1:    fbit = fsel[2];
      3'd2:    fbit = fsel[0];
      3'd3:    fbit = fsel[1];
      3'd4:    fbit = fsel[4];
      default: fbit = fsel[5];
    endcase
  end

  always_comb begin
    take = 1'b0;
    if (cond_sel >= 9'h080 && cond_sel <= 9'h0AE && !cond_sel[0])
      take = (fbit == cond_sel[1]);
    else case (cond_sel)
      9'h0B0: take = (dp_lo == 4'h0);
      9'h0B1: take = (dp_lo != 4'h0);
      9'h0B2: take = (dp_lo == 4'hF);
      9'h0B3: take = (dp_lo != 4'hF);
      9'h0BC: take = !rqm;
      9'h0BE: take = rqm;
      default: take = 1'b0;
    endcase
  end

  assign pc_d = is_so ? srl_out[PC_W-1:0] : (take ? tgt : seq_pc);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pc_q <= '0;
    else if (insn_vld) pc_q <= pc_d;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_vld |=> $stable(pc_q));
  assert_so_R3: assert property (@(posedge clk) disable iff (!rst_n)
    insn_vld && cond_sel == '0 |=> pc_q == $past(srl_out[PC_W-1:0]));
  assert_keep_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    insn_vld && cond_sel != '0 |=> pc_q[PC_W-1] == $past(pc_q[PC_W-1]) ||
      pc_q == $past(pc_q) + 1'b1);
  assert_ack_never_R6: assert property (@(posedge clk) disable iff (!rst_n)
    insn_vld && (cond_sel == 9'h0B4 || cond_sel == 9'h0B6 ||
                 cond_sel == 9'h0B8 || cond_sel == 9'h0BA)
    |=> pc_q == $past(pc_q) + 1'b1);
  assert_rqm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    insn_vld && cond_sel == 9'h0BE && rqm
    |=> pc_q == {$past(pc_q[PC_W-1]), $past(bank), $past(page_off)});
  assert_unassigned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    insn_vld && cond_sel == 9'h1FF |=> pc_q == $past(pc_q) + 1'b1);
endmodule

// File: tb/test_cbt_unit.sv
module test_cbt_unit;
  logic clk = 0, rst_n = 0, insn_vld = 0, rqm = 0;
  logic [8:0]  cond_sel = 0;
  logic [10:0] page_off = 0;
  logic [1:0]  bank = 0;
  logic [5:0]  flg_a = 0, flg_b = 0;
  logic [3:0]  dp_lo = 0;
  logic [15:0] srl_out = 0;
  logic [13:0] pc_q;
  int checks = 0, fails = 0;

  cbt_unit i_cbt_unit (.*);
  always #10 clk = ~clk;

  task automatic chk(string r, logic [13:0] exp);
    checks++;
    if (pc_q !== exp) begin
      fails++;
      $display("FAIL %s pc=%h expected=%h", r, pc_q, exp);
    end
  endtask

  // set pc via serial-out jump
  task automatic setpc(logic [13:0] v);
    @(negedge clk); cond_sel = 0; srl_out = {2'b00, v}; insn_vld = 1;
    @(negedge clk); insn_vld = 0;
  endtask

  // issue one branch from start pc; check taken or not
  task automatic br(string r, logic [13:0] start, logic [8:0] s, bit tk);
    logic [13:0] e;
    setpc(start);
    cond_sel = s; page_off = 11'h2A5; bank = 2'b10; insn_vld = 1;
    e = tk ? {start[13], 2'b10, 11'h2A5} : start + 14'd1;
    @(negedge clk); insn_vld = 0;
    chk(r, e);
  endtask

  task automatic t_reset;
    chk("R1", 14'h0);
    @(negedge clk); cond_sel = 9'h1FF; insn_vld = 0;
    @(negedge clk); chk("R1", 14'h0);
  endtask

  task automatic t_so;
    setpc(14'h1234); chk("R3", 14'h1234);
    @(negedge clk); cond_sel = 0; srl_out = 16'hFFFF; insn_vld = 1;
    @(negedge clk); insn_vld = 0; chk("R3", 14'h3FFF);
  endtask

  task automatic t_flags;
    int pos [6] = '{3, 2, 0, 1, 4, 5};
    for (int f = 0; f < 6; f++)
      for (int s = 0; s < 4; s++) begin
        logic [8:0] sel;
        bit setlvl;
        sel = 9'h080 + 9'(f * 8 + s * 2);
        setlvl = s[0];
        for (int v = 0; v < 2; v++) begin
          logic [5:0] vec;
          vec = v ? 6'(1 << pos[f]) : ~6'(1 << pos[f]);
          if (s >= 2) begin flg_b = vec; flg_a = ~vec; end
          else        begin flg_a = vec; flg_b = ~vec; end
          br("R4/R9", 14'h2000, sel, (v == 1) == setlvl);
        end
      end
    flg_a = 0; flg_b = 0;
  endtask

  task automatic t_dp;
    dp_lo = 0;    br("R5", 14'h0100, 9'h0B0, 1); br("R5", 14'h0100, 9'h0B1, 0);
    dp_lo = 4'hF; br("R5", 14'h0100, 9'h0B2, 1); br("R5", 14'h0100, 9'h0B3, 0);
    br("R5", 14'h0100, 9'h0B1, 1);
    dp_lo = 4'h7; br("R5", 14'h0100, 9'h0B0, 0); br("R5", 14'h0100, 9'h0B3, 1);
    br("R5", 14'h0100, 9'h0B2, 0);
  endtask

  task automatic t_ack;
    flg_a = '1; flg_b = '1; rqm = 1; dp_lo = 0;
    br("R6", 14'h0040, 9'h0B4, 0); br("R6", 14'h0040, 9'h0B6, 0);
    br("R6", 14'h0040, 9'h0B8, 0); br("R6", 14'h0040, 9'h0BA, 0);
    flg_a = 0; flg_b = 0;
  endtask

  task automatic t_rqm;
    rqm = 0; br("R7", 14'h0005, 9'h0BC, 1); br("R7", 14'h0005, 9'h0BE, 0);
    rqm = 1; br("R7", 14'h0005, 9'h0BC, 0); br("R7", 14'h0005, 9'h0BE, 1);
  endtask

  task automatic t_seq;
    br("R8", 14'h3FFF, 9'h1FF, 0);
    br("R8", 14'h0010, 9'h081, 0);
    br("R8 R2", 14'h3000, 9'h0BE, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset; t_so; t_flags; t_dp; t_ack; t_rqm; t_seq;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog pc=%h expected=done", pc_q);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule